// File: doc/BRIEF.md
# Dual-Bus Configuration Register Port

This block is the control-side slave of a mixed-signal function: it receives 16-bit control words from a host and keeps them in a small bank of 9-bit configuration registers. The contents of the whole bank are always visible as one flat parallel bus that the datapath decodes. A pin chooses the host bus. With the pin high, the block listens on a three-wire serial link: a clock, a data line and a strobe. With the pin low, it acts as a two-wire I2C target whose 7-bit address is set by the strobe pin.

Each control word carries a 7-bit register address in its upper seven bits and 9 bits of data in its lower nine. On I2C, a write splits the word across two bytes after the device address. The first of these bytes holds the address in bits 7..1 and the data MSB in bit 0. A read sets the address in the same way, then uses a repeated start. The left/right volume pairs can be loaded together with a single word, and one reserved address returns the whole bank to its power-on values.

The bus pins are sampled by the system clock through two-flop synchronizers. The host bus must therefore run at least a few system clocks per bus phase. The data line is open-drain: the block only ever pulls it low.

Top module: `ctl_regbank`

## Requirements
- R1: After reset, the registers hold these values (register n occupies reg_bank[9n+8:9n]): registers 0 and 1 = 0x097, registers 2 and 3 = 0x079, registers 4 and 7 = 0x00A, register 5 = 0x008, register 6 = 0x09F, registers 8 and 9 = 0x000.
- R2: With mode_sel = 1, bits are taken MSB first on rising edges of scl_pin while cs_pin is low. The word is applied when cs_pin rises: bits 15..9 give the register address and bits 8..0 give the data. The bank changes only through such a committed word or an I2C write.
- R3: In three-wire mode, a strobe period that saw any number of clock rises other than 16 changes no register.
- R4: With mode_sel = 1, sda_oe stays low.
- R5: With mode_sel = 0, the device address is 0011010 with bit 0 replaced by cs_pin. A write is start, address with R/W = 0, a byte {reg_addr[6:0], data[8]}, a byte data[7:0], stop. The block acknowledges each of these three bytes by asserting sda_oe during the ninth clock, and the register takes the data.
- R6: An I2C transfer to any other device address is not acknowledged and changes no register.
- R7: A write to register 0 or 1 with data bit 8 set stores the 9-bit value in both registers 0 and 1. The same holds for registers 2 and 3. With bit 8 clear, only the addressed register changes.
- R8: A write of any data to address 15, on either bus, returns every register to its R1 value.
- R9: A write to an address of 10 or above, other than 15, is acknowledged on I2C and changes no register.
- R10: An I2C read sends the register address byte {reg_addr, 0}, a repeated start and the device address with R/W = 1. The block then returns data[7:0], followed by a byte holding 0000000 and data[8]. An unmapped address reads as zero.
- R11: In an I2C write, a byte after the data byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Bus select: 1 three-wire, 0 I2C |
| cs_pin | input | 1 | Three-wire strobe; in I2C mode, the device address bit 0 |
| scl_pin | input | 1 | Serial clock of either bus |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull data line low when 1 |
| reg_bank | output | 90 | Register n in bits [9n+8:9n], n = 0..9 |

## Verification
A wrong bit counter, a misplaced field boundary or a broken pair link leaves a wrong value in reg_bank. The bench sees it within a few system clocks of the strobe edge or the data-byte clock, because it compares the full bank after every transfer. A stuck I2C state shows up on sda_oe as a missing or extra acknowledge in the same ninth clock. Read-back also shows it at once, since a misordered or shifted byte returns a wrong value.

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
  parameter int NREG = 10,
  parameter int DW = 9,
  parameter int AW = 7,
  parameter int RST_ADDR = 15,
  parameter logic [6:0] DEV_BASE = 7'b0011010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              cs_pin,
  input  logic              scl_pin,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [NREG*DW-1:0] reg_bank
);
  localparam int WW = AW + DW;
  localparam int CW = $clog2(WW + 2);
  localparam int IW = $clog2(NREG);

  function automatic logic [DW-1:0] dflt(input int i);
    case (i)
      0, 1:    return DW'(9'h097);
      2, 3:    return DW'(9'h079);
      4, 7:    return DW'(9'h00A);
      5:       return DW'(9'h008);
      6:       return DW'(9'h09F);
      default: return '0;
    endcase
  endfunction

  logic [2:0] scl_q, sda_q, cs_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1; sda_q <= '1; cs_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_pin};
      sda_q <= {sda_q[1:0], sda_in};
      cs_q  <= {cs_q[1:0], cs_pin};
    end

  wire scl_r = scl_q[1] & ~scl_q[2];
  wire scl_f = ~scl_q[1] & scl_q[2];
  wire sda_s = sda_q[1];
  wire bus_start = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire bus_stop  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire cs_rise = cs_q[1] & ~cs_q[2];
  wire cs_fall = ~cs_q[1] & cs_q[2];

  logic [DW-1:0] regs [NREG];

  // three-wire receiver
  logic [WW-1:0] sw;
  logic [CW-1:0] sw_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw <= '0; sw_cnt <= '0;
    end else if (!mode_sel || cs_fall) begin
      sw_cnt <= '0;
    end else if (scl_r && !cs_q[1]) begin
      sw <= {sw[WW-2:0], sda_s};
      if (sw_cnt != CW'(WW + 1)) sw_cnt <= sw_cnt + 1'b1;
    end
  wire spi_wr = mode_sel & cs_rise & (sw_cnt == CW'(WW));

  // I2C target
  typedef enum logic [2:0] {I_IDLE, I_RX, I_ACK, I_TX, I_MACK} ist_t;
  ist_t st;
  logic [3:0] bcnt;
  logic [7:0] sh;
  logic [1:0] bidx;
  logic rw, acc, d8, oe, hi, more;
  logic [AW-1:0] ra;

  wire [7:0] byte_now = {sh[6:0], sda_s};
  wire [6:0] dev_addr = {DEV_BASE[6:1], DEV_BASE[0] | cs_q[1]};
  wire [DW-1:0] rdata = (ra < AW'(NREG)) ? regs[ra[IW-1:0]] : '0;
  wire [7:0] nxt_byte = hi ? {7'b0, rdata[DW-1]} : rdata[7:0];
  wire i2c_wr = ~mode_sel & (st == I_RX) & scl_r & (bcnt == 4'd7) & (bidx == 2'd2) & ~rw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= I_IDLE; bcnt <= '0; sh <= '0; bidx <= '0; rw <= 1'b0; acc <= 1'b0;
      d8 <= 1'b0; oe <= 1'b0; hi <= 1'b0; more <= 1'b0; ra <= '0;
    end else if (mode_sel) begin
      st <= I_IDLE; oe <= 1'b0;
    end else if (bus_start) begin
      st <= I_RX; bcnt <= '0; bidx <= '0; oe <= 1'b0; rw <= 1'b0;
    end else if (bus_stop) begin
      st <= I_IDLE; oe <= 1'b0;
    end else begin
      case (st)
        I_RX:
          if (scl_r && bcnt != 4'd8) begin
            sh <= byte_now;
            bcnt <= bcnt + 1'b1;
            if (bcnt == 4'd7) begin
              if (bidx != 2'd3) bidx <= bidx + 1'b1;
              case (bidx)
                2'd0: begin acc <= (byte_now[7:1] == dev_addr); rw <= byte_now[0]; end
                2'd1: begin acc <= 1'b1; ra <= byte_now[7:1]; d8 <= byte_now[0]; end
                2'd2: acc <= 1'b1;
                default: acc <= 1'b0;
              endcase
            end
          end else if (scl_f && bcnt == 4'd8) begin
            bcnt <= '0;
            if (acc) begin oe <= 1'b1; st <= I_ACK; end
            else st <= I_IDLE;
          end
        I_ACK:
          if (scl_f) begin
            bcnt <= '0;
            if (rw) begin
              st <= I_TX; sh <= rdata[7:0]; oe <= ~rdata[7]; hi <= 1'b1;
            end else begin
              st <= I_RX; oe <= 1'b0;
            end
          end
        I_TX:
          if (scl_f) begin
            if (bcnt == 4'd7) begin
              oe <= 1'b0; st <= I_MACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; oe <= ~sh[6]; bcnt <= bcnt + 1'b1;
            end
          end
        I_MACK:
          if (scl_r) more <= ~sda_s;
          else if (scl_f) begin
            bcnt <= '0;
            if (more) begin
              st <= I_TX; sh <= nxt_byte; oe <= ~nxt_byte[7]; hi <= ~hi;
            end else st <= I_IDLE;
          end
        default: ;
      endcase
    end
  assign sda_oe = oe;

  // register bank
  wire           wr_en   = spi_wr | i2c_wr;
  wire [AW-1:0]  wr_addr = mode_sel ? sw[WW-1:DW] : ra;
  wire [DW-1:0]  wr_data = mode_sel ? sw[DW-1:0] : {d8, byte_now};
  wire [IW-1:0]  wr_idx  = wr_addr[IW-1:0];
  wire [IW-1:0]  pair_idx = {wr_idx[IW-1:1], ~wr_idx[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else if (wr_en) begin
      if (wr_addr == AW'(RST_ADDR)) begin
        for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
      end else if (wr_addr < AW'(NREG)) begin
        regs[wr_idx] <= wr_data;
        if (wr_addr < AW'(4) && wr_data[DW-1]) regs[pair_idx] <= wr_data;
      end
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_bank[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk #(
  parameter int NREG = 10,
  parameter int DW = 9,
  parameter int AW = 7,
  parameter int RST_ADDR = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_sel,
  input logic               sda_oe,
  input logic [NREG*DW-1:0] reg_bank,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data
);
  logic [NREG*DW-1:0] def_snap;
  always_ff @(posedge clk) if (!rst_n) def_snap <= reg_bank;

  function automatic logic [DW-1:0] pick(input logic [NREG*DW-1:0] b, input int idx);
    return b[idx*DW +: DW];
  endfunction

  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == AW'(RST_ADDR) |=> reg_bank == def_snap);

  a_r7_linked_pair: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr < AW'(4) && wr_data[DW-1] |=>
      pick(reg_bank, int'($past(wr_addr)) ^ 1) == $past(wr_data) &&
      pick(reg_bank, int'($past(wr_addr))) == $past(wr_data));

  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr >= AW'(NREG) && wr_addr != AW'(RST_ADDR) |=> $stable(reg_bank));

  a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_bank));

  a_r4_no_drive_3wire: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel && $past(mode_sel) |-> !sda_oe);
endmodule

bind ctl_regbank ctl_regbank_chk #(.NREG(NREG), .DW(DW), .AW(AW), .RST_ADDR(RST_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sda_oe(sda_oe), .reg_bank(reg_bank),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/test_ctl_regbank.sv
module test_ctl_regbank;
  localparam int H = 6;
  logic clk = 1'b0, rst_n = 1'b0, mode_sel = 1'b1, cs_pin = 1'b1, scl_pin = 1'b0, sda_m = 1'b1;
  logic sda_oe;
  logic [89:0] reg_bank;
  wire sda_in = sda_m & ~sda_oe;
  int total = 0, fails = 0;
  bit oe_seen;
  logic [8:0] mdl [10];

  always #5 clk = ~clk;

  ctl_regbank i_ctl_regbank (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_pin(cs_pin),
    .scl_pin(scl_pin), .sda_in(sda_in), .sda_oe(sda_oe), .reg_bank(reg_bank));

  always @(negedge clk) if (mode_sel && sda_oe) oe_seen = 1'b1;

  function automatic logic [8:0] dflt_b(input int i);
    case (i)
      0, 1: return 9'h097;
      2, 3: return 9'h079;
      4, 7: return 9'h00A;
      5:    return 9'h008;
      6:    return 9'h09F;
      default: return 9'h000;
    endcase
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < 10; i++) mdl[i] = dflt_b(i);
  endtask

  task automatic mdl_write(input int a, input logic [8:0] d);
    if (a == 15) mdl_reset();
    else if (a < 10) begin
      mdl[a] = d;
      if (a < 4 && d[8]) mdl[a ^ 1] = d;
    end
  endtask

  function automatic logic [89:0] bank_exp();
    logic [89:0] f;
    for (int i = 0; i < 10; i++) f[i*9 +: 9] = mdl[i];
    return f;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [15:0] w, input int nclk);
    cs_pin = 1'b0; hold(H);
    for (int i = 0; i < nclk; i++) begin
      sda_m = (i < 16) ? w[15-i] : 1'b0;
      hold(H); scl_pin = 1'b1; hold(H); scl_pin = 1'b0;
    end
    hold(H); cs_pin = 1'b1; hold(2*H);
    sda_m = 1'b1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hold(H); scl_pin = 1'b1; hold(H); sda_m = 1'b0; hold(H); scl_pin = 1'b0; hold(H);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hold(H); scl_pin = 1'b1; hold(H); sda_m = 1'b1; hold(2*H);
  endtask

  task automatic i2c_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(H); scl_pin = 1'b1; hold(H); scl_pin = 1'b0;
    end
    sda_m = 1'b1; hold(H); scl_pin = 1'b1; hold(H);
    ack = ~sda_in;
    scl_pin = 1'b0; hold(H);
  endtask

  task automatic i2c_recv(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H); scl_pin = 1'b1; hold(H); b[i] = sda_in; scl_pin = 1'b0;
    end
    sda_m = ~mack; hold(H); scl_pin = 1'b1; hold(H); scl_pin = 1'b0; hold(H);
    sda_m = 1'b1;
  endtask

  task automatic i2c_wr(input logic [6:0] dev, input logic [6:0] a, input logic [8:0] d,
                        output logic [2:0] acks);
    i2c_start();
    i2c_send({dev, 1'b0}, acks[2]);
    i2c_send({a, d[8]}, acks[1]);
    i2c_send(d[7:0], acks[0]);
    i2c_stop();
  endtask

  task automatic i2c_rd(input logic [6:0] dev, input logic [6:0] a, output logic [15:0] v,
                        output logic [2:0] acks);
    logic [7:0] lo, hi;
    i2c_start();
    i2c_send({dev, 1'b0}, acks[2]);
    i2c_send({a, 1'b0}, acks[1]);
    i2c_start();
    i2c_send({dev, 1'b1}, acks[0]);
    i2c_recv(1'b1, lo);
    i2c_recv(1'b0, hi);
    i2c_stop();
    v = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [15:0] rv;
    logic [6:0] dev0, dev1;
    dev0 = 7'b0011010; dev1 = 7'b0011011;
    void'($urandom(32'd4242));
    mdl_reset();
    hold(10); rst_n = 1'b1; hold(5);
    chk("R1 reset defaults", reg_bank, bank_exp());
    chk("R4 sda idle after reset", sda_oe, 0);

    // three-wire directed
    spi_xfer({7'd4, 9'h1A5}, 16); mdl_write(4, 9'h1A5);
    chk("R2 three-wire write reg4", reg_bank, bank_exp());
    spi_xfer({7'd9, 9'h0F3}, 16); mdl_write(9, 9'h0F3);
    chk("R2 three-wire write reg9", reg_bank, bank_exp());
    spi_xfer({7'd5, 9'h155}, 15);
    chk("R3 fifteen clocks discarded", reg_bank, bank_exp());
    spi_xfer({7'd5, 9'h155}, 17);
    chk("R3 seventeen clocks discarded", reg_bank, bank_exp());
    spi_xfer({7'd0, 9'h12A}, 16); mdl_write(0, 9'h12A);
    chk("R7 linked write reg0 to reg1", reg_bank, bank_exp());
    spi_xfer({7'd3, 9'h165}, 16); mdl_write(3, 9'h165);
    chk("R7 linked write reg3 to reg2", reg_bank, bank_exp());
    spi_xfer({7'd2, 9'h044}, 16); mdl_write(2, 9'h044);
    chk("R7 unlinked write only reg2", reg_bank, bank_exp());
    spi_xfer({7'd12, 9'h1FF}, 16);
    chk("R9 three-wire unmapped ignored", reg_bank, bank_exp());
    for (int k = 0; k < 40; k++) begin
      int a; logic [8:0] d;
      a = $urandom % 16; d = 9'($urandom);
      spi_xfer({7'(a), d}, 16); mdl_write(a, d);
      chk("R2 random three-wire", reg_bank, bank_exp());
    end
    spi_xfer({7'd15, 9'h1B3}, 16); mdl_write(15, 9'h1B3);
    chk("R8 three-wire soft reset", reg_bank, bank_exp());
    chk("R4 no data drive in three-wire mode", oe_seen, 0);

    // I2C
    mode_sel = 1'b0; scl_pin = 1'b1; sda_m = 1'b1; cs_pin = 1'b0; hold(4*H);
    i2c_wr(dev0, 7'd5, 9'h011, acks); mdl_write(5, 9'h011);
    chk("R5 write acks cs=0", acks, 3'b111);
    chk("R5 write data cs=0", reg_bank, bank_exp());
    cs_pin = 1'b1; hold(2*H);
    i2c_wr(dev1, 7'd6, 9'h123, acks); mdl_write(6, 9'h123);
    chk("R5 write acks cs=1", acks, 3'b111);
    chk("R5 write data cs=1", reg_bank, bank_exp());
    i2c_wr(dev0, 7'd6, 9'h0AA, acks);
    chk("R6 wrong device not acked", acks[2], 0);
    chk("R6 wrong device no change", reg_bank, bank_exp());
    i2c_wr(dev1, 7'h20, 9'h1EE, acks);
    chk("R9 unmapped write acked", acks, 3'b111);
    chk("R9 unmapped write ignored", reg_bank, bank_exp());
    i2c_start();
    i2c_send({dev1, 1'b0}, acks[2]);
    i2c_send({7'd8, 1'b0}, acks[1]);
    i2c_send(8'h5C, acks[0]); mdl_write(8, 9'h05C);
    begin
      logic extra;
      i2c_send(8'h77, extra);
      chk("R11 byte after data not acked", extra, 0);
    end
    i2c_stop();
    chk("R11 first word kept", reg_bank, bank_exp());
    i2c_rd(dev1, 7'd6, rv, acks);
    chk("R10 read acks", acks, 3'b111);
    chk("R10 read reg6 low then high", rv, {7'b0, mdl[6][8], mdl[6][7:0]});
    i2c_rd(dev1, 7'd11, rv, acks);
    chk("R10 unmapped read zero", rv, 16'h0000);
    i2c_wr(dev1, 7'd1, 9'h1C0, acks); mdl_write(1, 9'h1C0);
    chk("R7 I2C linked write reg1 to reg0", reg_bank, bank_exp());
    for (int k = 0; k < 14; k++) begin
      int a, ra; logic [8:0] d; logic c; logic [6:0] dv;
      c = 1'($urandom); cs_pin = c; hold(2*H);
      dv = c ? dev1 : dev0;
      a = $urandom % 15; d = 9'($urandom);
      i2c_wr(dv, 7'(a), d, acks); mdl_write(a, d);
      chk("R5 random I2C write", reg_bank, bank_exp());
      ra = $urandom % 12;
      i2c_rd(dv, 7'(ra), rv, acks);
      chk("R10 random I2C read", rv, (ra < 10) ? {7'b0, mdl[ra]} : 16'h0);
    end
    i2c_wr(cs_pin ? dev1 : dev0, 7'd15, 9'h000, acks); mdl_write(15, 9'h000);
    chk("R8 I2C soft reset", reg_bank, bank_exp());

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule